// File: doc/BRIEF.md
# Address-space-tagged fully associative translation cache

This block caches recent virtual-to-physical page translations so that a lookup finishes in the same cycle it is presented. Every slot holds a virtual page number, a physical page number, an address-space tag, and a set of attribute flags: global, large page, user-accessible, writable, dirty and uncached. A lookup takes a full virtual address, a write flag and a user-mode flag. The block compares the address against every slot at once. On a hit the stored physical page number replaces the virtual one, and the page offset passes through unchanged.

A non-global slot matches only when its stored tag equals the current address-space register. Software loads that register on a context switch, so translations from other processes stay resident but never match. Global slots match under any tag. Large-page slots leave the low VPN bits out of the compare and map a region 2^SP_BITS times larger than a normal page.

Fills arrive on a valid/ready port after a miss has been handled elsewhere. Maintenance inputs remove slots by VPN or flush every non-global slot. They take priority over a fill: `fill_ready` is low in any cycle where maintenance is requested, and a fill is accepted only when `fill_valid` and `fill_ready` are both high at a clock edge. The lookup port has no back-pressure. A miss only deasserts `lk_hit`. The block never stalls or retries, and it does not walk page tables.

Top module: `tlb_asid_fa`

## Requirements
- R1: After reset every slot is empty, the address-space register is 0, every lookup misses with `lk_fault` low, and `fill_ready` is high.
- R2: A fill accepted at edge t is visible to a lookup in the cycle after t, with no further delay. On a hit, `lk_pa` is the stored physical page number in bits [31:12] and the virtual address bits [11:0] unchanged.
- R3: A non-global slot matches only if its stored tag equals the address-space register. A write through `asid_we` takes effect in the cycle after the edge that captures it.
- R4: A slot filled with the global flag set matches regardless of the address-space register.
- R5: For a slot filled with the large-page flag set, VPN bits [SP_BITS-1:0] are left out of the compare. The physical page number bits [SP_BITS-1:0] of `lk_pa` are then taken from the looked-up VPN.
- R6: A matching slot raises `lk_fault` with `lk_hit` low in two cases: a write to a slot whose writable flag is 0, or a user access to a slot whose user flag is 0. On a hit, `lk_nocache` and `lk_dirty` report the slot's uncached and dirty flags.
- R7: `inv_valid` removes at the next edge every slot whose VPN equals `inv_vpn` under that slot's own compare mask, in any address space, and leaves every other slot intact.
- R8: `flush_ng` removes at the next edge every non-global slot and keeps every global slot.
- R9: A fill that replaces no existing slot goes into the lowest-index empty slot. When no slot is empty, it goes into the slot named by a round-robin pointer, which starts at 0 and advances by one, wrapping, only on such fills.
- R10: A fill whose key equals a valid slot's key overwrites that slot, so no duplicate match arises. Two keys are equal when the large-page flag is the same, the VPN is the same under the compare mask, and either both slots are global or both are non-global with the same tag.
- R11: `fill_ready` is low whenever `inv_valid` or `flush_ng` is high, and a fill offered in such a cycle changes no slot.
- R12: When several slots match, the lowest-index slot supplies the result.
- R13: With `lk_valid` low, `lk_hit` and `lk_fault` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asid_we | input | 1 | Load the address-space register |
| asid_wdata | input | ASID_W | New address-space value |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | VPN_W+OFF_W | Virtual address to translate |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| lk_hit | output | 1 | Translation found, access permitted |
| lk_fault | output | 1 | Translation found, access refused |
| lk_pa | output | PPN_W+OFF_W | Physical address (0 when not a hit) |
| lk_nocache | output | 1 | Hit slot is uncached |
| lk_dirty | output | 1 | Hit slot is marked dirty |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_vpn | input | VPN_W | Fill virtual page number |
| fill_ppn | input | PPN_W | Fill physical page number |
| fill_asid | input | ASID_W | Fill address-space tag |
| fill_global | input | 1 | Fill is global |
| fill_super | input | 1 | Fill is a large page |
| fill_user | input | 1 | Fill allows user access |
| fill_writable | input | 1 | Fill allows writes |
| fill_dirty | input | 1 | Fill dirty flag |
| fill_nocache | input | 1 | Fill uncached flag |
| inv_valid | input | 1 | Remove slots matching inv_vpn |
| inv_vpn | input | VPN_W | VPN to remove |
| flush_ng | input | 1 | Remove all non-global slots |

## Verification
The bench builds the block with its defaults: 32 slots, a 20-bit VPN and PPN, a 12-bit offset, 8-bit tags and SP_BITS of 10. With 32 slots, a directed run of 33 fills reaches the full-array round-robin path in a few dozen cycles. The random phase draws VPNs from a handful of large-page regions and three tags. This makes large-page and normal-page overlaps, same-key refills and tag mismatches occur often. It also makes evictions happen while invalidations and flushes are interleaved.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Per-slot attribute flags, fixed width regardless of block parameters.
  typedef struct packed {
    logic glob;   // matches in every address space, survives flush
    logic sup;    // large page: low VPN bits excluded from compare
    logic usr;    // user-mode access allowed
    logic wr;     // writes allowed
    logic dirty;  // page has been written
    logic nc;     // uncached (memory-mapped I/O)
  } tlb_attr_t;

  // Why a slot was chosen for a fill.
  typedef enum logic [1:0] {
    VIC_SAME = 2'd0,
    VIC_FREE = 2'd1,
    VIC_RR   = 2'd2
  } vic_src_t;

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned SP_BITS = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [VPN_W-1:0]           lk_vpn,
  input  logic [ASID_W-1:0]          cur_asid,
  output logic [ENTRIES-1:0]         lk_match,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [PPN_W-1:0]           wr_ppn,
  input  logic [ASID_W-1:0]          wr_asid,
  input  tlb_attr_t                  wr_attr,
  output logic [ENTRIES-1:0]         same_key,
  input  logic                       inv_en,
  input  logic [VPN_W-1:0]           inv_vpn,
  input  logic                       flush_ng,
  output logic [ENTRIES-1:0]         valid_vec,
  output logic [ENTRIES-1:0]         glob_vec,
  output logic [PPN_W-1:0]           ent_ppn  [ENTRIES],
  output tlb_attr_t                  ent_attr [ENTRIES]
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam logic [VPN_W-1:0] BIG_MASK =
    {{(VPN_W-SP_BITS){1'b1}}, {SP_BITS{1'b0}}};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic             v_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic [ASID_W-1:0] asid_q;
    tlb_attr_t        attr_q;
    logic [VPN_W-1:0] cmp_mask;
    logic             inv_hit;
    logic             wr_sel;

    assign cmp_mask = attr_q.sup ? BIG_MASK : '1;
    assign wr_sel   = wr_en && (wr_idx == IDX_W'(i));

    assign lk_match[i] = v_q
                      && (((lk_vpn ^ vpn_q) & cmp_mask) == '0)
                      && (attr_q.glob || (asid_q == cur_asid));

    assign inv_hit = v_q && (((inv_vpn ^ vpn_q) & cmp_mask) == '0);

    assign same_key[i] = v_q
                      && (attr_q.sup == wr_attr.sup)
                      && (((wr_vpn ^ vpn_q) & cmp_mask) == '0)
                      && ((attr_q.glob && wr_attr.glob)
                          || (!attr_q.glob && !wr_attr.glob && asid_q == wr_asid));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (flush_ng && !attr_q.glob) begin
        v_q <= 1'b0;
      end else if (inv_en && inv_hit) begin
        v_q <= 1'b0;
      end else if (wr_sel) begin
        v_q <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vpn_q  <= '0;
        ppn_q  <= '0;
        asid_q <= '0;
        attr_q <= '0;
      end else if (wr_sel) begin
        vpn_q  <= wr_vpn;
        ppn_q  <= wr_ppn;
        asid_q <= wr_asid;
        attr_q <= wr_attr;
      end
    end

    assign valid_vec[i] = v_q;
    assign glob_vec[i]  = attr_q.glob;
    assign ent_ppn[i]   = ppn_q;
    assign ent_attr[i]  = attr_q;
  end

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ENTRIES-1:0]         valid_vec,
  input  logic [ENTRIES-1:0]         same_key,
  input  logic                       take,
  output logic [$clog2(ENTRIES)-1:0] vic_idx
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] same_idx, free_idx;
  logic             same_any, free_any;
  vic_src_t         src;

  always_comb begin
    same_any = 1'b0;
    same_idx = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!same_any && same_key[i]) begin
        same_any = 1'b1;
        same_idx = IDX_W'(i);
      end
      if (!free_any && !valid_vec[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (same_any) begin
      src     = VIC_SAME;
      vic_idx = same_idx;
    end else if (free_any) begin
      src     = VIC_FREE;
      vic_idx = free_idx;
    end else begin
      src     = VIC_RR;
      vic_idx = rr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (take && src == VIC_RR) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_resp_mux.sv
module tlb_resp_mux
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned SP_BITS = 10
) (
  input  logic                   lk_valid,
  input  logic [VPN_W+OFF_W-1:0] lk_va,
  input  logic                   lk_write,
  input  logic                   lk_user,
  input  logic [ENTRIES-1:0]     lk_match,
  input  logic [PPN_W-1:0]       ent_ppn  [ENTRIES],
  input  tlb_attr_t              ent_attr [ENTRIES],
  output logic                   lk_hit,
  output logic                   lk_fault,
  output logic [PPN_W+OFF_W-1:0] lk_pa,
  output logic                   lk_nocache,
  output logic                   lk_dirty
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] sel;
  logic             any;
  logic [PPN_W-1:0] ppn, ppn_eff;
  tlb_attr_t        attr;
  logic [VPN_W-1:0] vpn;

  assign vpn = lk_va[VPN_W+OFF_W-1:OFF_W];

  // Lowest-index match wins.
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!any && lk_match[i]) begin
        any = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign ppn  = ent_ppn[sel];
  assign attr = ent_attr[sel];

  assign ppn_eff = attr.sup ? {ppn[PPN_W-1:SP_BITS], vpn[SP_BITS-1:0]} : ppn;

  assign lk_fault   = lk_valid && any && ((lk_write && !attr.wr) || (lk_user && !attr.usr));
  assign lk_hit     = lk_valid && any && !lk_fault;
  assign lk_pa      = lk_hit ? {ppn_eff, lk_va[OFF_W-1:0]} : '0;
  assign lk_nocache = lk_hit && attr.nc;
  assign lk_dirty   = lk_hit && attr.dirty;

endmodule

// File: rtl/tlb_asid_fa.sv
module tlb_asid_fa
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned SP_BITS = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   asid_we,
  input  logic [ASID_W-1:0]      asid_wdata,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFF_W-1:0] lk_va,
  input  logic                   lk_write,
  input  logic                   lk_user,
  output logic                   lk_hit,
  output logic                   lk_fault,
  output logic [PPN_W+OFF_W-1:0] lk_pa,
  output logic                   lk_nocache,
  output logic                   lk_dirty,
  input  logic                   fill_valid,
  output logic                   fill_ready,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic [ASID_W-1:0]      fill_asid,
  input  logic                   fill_global,
  input  logic                   fill_super,
  input  logic                   fill_user,
  input  logic                   fill_writable,
  input  logic                   fill_dirty,
  input  logic                   fill_nocache,
  input  logic                   inv_valid,
  input  logic [VPN_W-1:0]       inv_vpn,
  input  logic                   flush_ng
);

  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ASID_W-1:0]  cur_asid_q;
  logic [ENTRIES-1:0] lk_match, same_key, valid_vec, glob_vec;
  logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
  tlb_attr_t          ent_attr [ENTRIES];
  logic [IDX_W-1:0]   vic_idx;
  logic               fill_fire;
  tlb_attr_t          fill_attr;

  assign fill_ready = !(inv_valid || flush_ng);
  assign fill_fire  = fill_valid && fill_ready;

  assign fill_attr = '{glob:  fill_global,
                       sup:   fill_super,
                       usr:   fill_user,
                       wr:    fill_writable,
                       dirty: fill_dirty,
                       nc:    fill_nocache};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_asid_q <= '0;
    end else if (asid_we) begin
      cur_asid_q <= asid_wdata;
    end
  end

  tlb_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
    .ASID_W(ASID_W), .SP_BITS(SP_BITS)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (lk_va[VPN_W+OFF_W-1:OFF_W]),
    .cur_asid (cur_asid_q),
    .lk_match (lk_match),
    .wr_en    (fill_fire),
    .wr_idx   (vic_idx),
    .wr_vpn   (fill_vpn),
    .wr_ppn   (fill_ppn),
    .wr_asid  (fill_asid),
    .wr_attr  (fill_attr),
    .same_key (same_key),
    .inv_en   (inv_valid),
    .inv_vpn  (inv_vpn),
    .flush_ng (flush_ng),
    .valid_vec(valid_vec),
    .glob_vec (glob_vec),
    .ent_ppn  (ent_ppn),
    .ent_attr (ent_attr)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_vec(valid_vec),
    .same_key (same_key),
    .take     (fill_fire),
    .vic_idx  (vic_idx)
  );

  tlb_resp_mux #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
    .OFF_W(OFF_W), .SP_BITS(SP_BITS)
  ) u_resp (
    .lk_valid  (lk_valid),
    .lk_va     (lk_va),
    .lk_write  (lk_write),
    .lk_user   (lk_user),
    .lk_match  (lk_match),
    .ent_ppn   (ent_ppn),
    .ent_attr  (ent_attr),
    .lk_hit    (lk_hit),
    .lk_fault  (lk_fault),
    .lk_pa     (lk_pa),
    .lk_nocache(lk_nocache),
    .lk_dirty  (lk_dirty)
  );

endmodule

// File: rtl/tlb_asid_fa_chk.sv
module tlb_asid_fa_chk #(
  parameter int unsigned ENTRIES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               lk_fault,
  input logic               fill_valid,
  input logic               fill_ready,
  input logic               inv_valid,
  input logic               flush_ng,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] glob_vec
);

  // R6: a refused access never also reports a hit
  a_r6_hit_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));

  // R13: no response without a request
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_fault));

  // R1: an empty array cannot produce a match
  a_r1_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec == '0) |-> (!lk_hit && !lk_fault));

  // R8: flush leaves no non-global slot valid
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ng |=> ((valid_vec & ~glob_vec) == '0));

  // R8: flush alone keeps global slots
  a_r8_flush_keeps_global: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_ng && !inv_valid) |=> ((valid_vec & glob_vec) == $past(valid_vec & glob_vec)));

  // R11: maintenance blocks fills and a blocked fill adds no slot
  a_r11_fill_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid || flush_ng) |-> !fill_ready);

  a_r11_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && (inv_valid || flush_ng)) |=>
      ($countones(valid_vec) <= $past($countones(valid_vec))));

endmodule

bind tlb_asid_fa tlb_asid_fa_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_hit    (lk_hit),
  .lk_fault  (lk_fault),
  .fill_valid(fill_valid),
  .fill_ready(fill_ready),
  .inv_valid (inv_valid),
  .flush_ng  (flush_ng),
  .valid_vec (valid_vec),
  .glob_vec  (glob_vec)
);

// File: tb/tlb_asid_fa_tb.sv
`timescale 1ns/1ps
module tlb_asid_fa_tb;

  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        asid_we;
  logic [7:0]  asid_wdata;
  logic        lk_valid, lk_write, lk_user;
  logic [31:0] lk_va;
  logic        lk_hit, lk_fault, lk_nocache, lk_dirty;
  logic [31:0] lk_pa;
  logic        fill_valid, fill_ready;
  logic [19:0] fill_vpn, fill_ppn;
  logic [7:0]  fill_asid;
  logic        fill_global, fill_super, fill_user, fill_writable, fill_dirty, fill_nocache;
  logic        inv_valid, flush_ng;
  logic [19:0] inv_vpn;

  always #10 clk = ~clk;  // 50 MHz

  tlb_asid_fa u_dut (.*);

  typedef struct {
    bit        v;
    bit [19:0] vpn;
    bit [19:0] ppn;
    bit [7:0]  asid;
    bit        g, s, u, w, d, nc;
  } ent_t;

  ent_t    m [N];
  int      rr;
  bit [7:0] cur;
  int      checks = 0;
  int      errors = 0;
  bit      done = 0;

  function automatic bit [19:0] mk(bit s);
    return s ? 20'hFFC00 : 20'hFFFFF;
  endfunction

  function automatic int m_find(bit [19:0] vpn);
    for (int i = 0; i < N; i++)
      if (m[i].v && ((vpn ^ m[i].vpn) & mk(m[i].s)) == 0 && (m[i].g || m[i].asid == cur))
        return i;
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m[i] = '{default: 0};
    rr = 0;
    cur = 0;
  endtask

  task automatic idle();
    asid_we = 0; asid_wdata = 0;
    lk_valid = 0; lk_va = 0; lk_write = 0; lk_user = 0;
    fill_valid = 0; fill_vpn = 0; fill_ppn = 0; fill_asid = 0;
    fill_global = 0; fill_super = 0; fill_user = 0; fill_writable = 0;
    fill_dirty = 0; fill_nocache = 0;
    inv_valid = 0; inv_vpn = 0; flush_ng = 0;
  endtask

  // Compare every output with the model, mid-cycle.
  task automatic settle();
    int idx;
    bit ex_any, ex_fault, ex_hit;
    bit [19:0] pp;
    #5;
    idx = m_find(lk_va[31:12]);
    ex_any = lk_valid && idx >= 0;
    ex_fault = 0;
    if (ex_any) ex_fault = (lk_write && !m[idx].w) || (lk_user && !m[idx].u);
    ex_hit = ex_any && !ex_fault;
    chk("R3 hit", {31'd0, lk_hit}, {31'd0, ex_hit});
    chk("R6 fault", {31'd0, lk_fault}, {31'd0, ex_fault});
    chk("R11 ready", {31'd0, fill_ready}, {31'd0, !(inv_valid || flush_ng)});
    if (ex_hit) begin
      pp = m[idx].s ? {m[idx].ppn[19:10], lk_va[21:12]} : m[idx].ppn;
      chk("R2 pa", lk_pa, {pp, lk_va[11:0]});
      chk("R6 nocache", {31'd0, lk_nocache}, {31'd0, m[idx].nc});
      chk("R6 dirty", {31'd0, lk_dirty}, {31'd0, m[idx].d});
    end
  endtask

  task automatic adv();
    int slot;
    @(posedge clk);
    if (flush_ng || inv_valid) begin
      for (int i = 0; i < N; i++) begin
        if (flush_ng && !m[i].g) m[i].v = 0;
        if (inv_valid && ((inv_vpn ^ m[i].vpn) & mk(m[i].s)) == 0) m[i].v = 0;
      end
    end else if (fill_valid) begin
      slot = -1;
      for (int i = 0; i < N && slot < 0; i++)
        if (m[i].v && m[i].s == fill_super && ((fill_vpn ^ m[i].vpn) & mk(m[i].s)) == 0 &&
            ((m[i].g && fill_global) || (!m[i].g && !fill_global && m[i].asid == fill_asid)))
          slot = i;
      for (int i = 0; i < N && slot < 0; i++)
        if (!m[i].v) slot = i;
      if (slot < 0) begin
        slot = rr;
        rr = (rr + 1) % N;
      end
      m[slot] = '{1, fill_vpn, fill_ppn, fill_asid, fill_global, fill_super,
                  fill_user, fill_writable, fill_dirty, fill_nocache};
    end
    if (asid_we) cur = asid_wdata;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle();
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fill(bit [19:0] vpn, bit [19:0] ppn, bit [7:0] asid,
                      bit g, bit s, bit u, bit w, bit d, bit nc);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_asid = asid;
    fill_global = g; fill_super = s; fill_user = u; fill_writable = w;
    fill_dirty = d; fill_nocache = nc;
    settle();
    adv();
  endtask

  task automatic look(bit [31:0] va, bit w, bit u);
    lk_valid = 1; lk_va = va; lk_write = w; lk_user = u;
    settle();
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    idle();
    do_reset();

    // R1: reset state
    look(32'h1234_5678, 0, 0);
    chk("R1 hit", {31'd0, lk_hit}, 0);
    chk("R1 fault", {31'd0, lk_fault}, 0);
    chk("R1 ready", {31'd0, fill_ready}, 1);
    adv();

    // R2: fill then hit next cycle
    fill(20'h12345, 20'hABCDE, 8'd0, 0, 0, 1, 1, 1, 0);
    look(32'h1234_5678, 1, 1);
    chk("R2 hit", {31'd0, lk_hit}, 1);
    chk("R2 pa", lk_pa, 32'hABCD_E678);
    chk("R6 dirty", {31'd0, lk_dirty}, 1);
    adv();
    // R13: no request, no response
    lk_va = 32'h1234_5678;
    settle();
    chk("R13 hit", {31'd0, lk_hit}, 0);
    adv();

    // R3: tag mismatch after context switch
    asid_we = 1; asid_wdata = 8'd5;
    settle();
    adv();
    look(32'h1234_5678, 0, 0);
    chk("R3 other tag", {31'd0, lk_hit}, 0);
    adv();
    // R4: global entry hits under any tag
    fill(20'h00777, 20'h00333, 8'd9, 1, 0, 1, 1, 0, 0);
    look(32'h0077_7ABC, 0, 1);
    chk("R4 global", lk_pa, 32'h0033_3ABC);
    adv();
    asid_we = 1; asid_wdata = 8'd0;
    settle();
    adv();
    look(32'h1234_5678, 0, 0);
    chk("R3 tag back", {31'd0, lk_hit}, 1);
    adv();

    // R5: large page
    fill(20'h40000, 20'h55400, 8'd0, 0, 1, 1, 0, 0, 1);
    look(32'h4012_3456, 0, 1);
    chk("R5 pa", lk_pa, 32'h5552_3456);
    chk("R6 nocache", {31'd0, lk_nocache}, 1);
    adv();
    // R6: write to read-only
    look(32'h4012_3456, 1, 0);
    chk("R6 ro fault", {31'd0, lk_fault}, 1);
    chk("R6 ro hit", {31'd0, lk_hit}, 0);
    adv();
    // R6: user on supervisor page
    fill(20'h00100, 20'h00200, 8'd0, 0, 0, 0, 1, 0, 0);
    look(32'h0010_0000, 0, 1);
    chk("R6 sup fault", {31'd0, lk_fault}, 1);
    adv();
    look(32'h0010_0000, 0, 0);
    chk("R6 sup ok", {31'd0, lk_hit}, 1);
    adv();

    // R10: same-key refill overwrites
    fill(20'h12345, 20'h11111, 8'd0, 0, 0, 1, 1, 0, 0);
    look(32'h1234_5678, 0, 0);
    chk("R10 refill", lk_pa, 32'h1111_1678);
    adv();

    // R12: lowest-index match wins
    fill(20'h80000, 20'h90000, 8'd0, 0, 1, 1, 1, 0, 0);
    fill(20'h80005, 20'h70000, 8'd0, 0, 0, 1, 1, 0, 0);
    look(32'h8000_5010, 0, 0);
    chk("R12 lowest", lk_pa, 32'h9000_5010);
    adv();
    // R7: invalidate removes both overlapping slots, keeps others
    inv_valid = 1; inv_vpn = 20'h80005;
    settle();
    adv();
    look(32'h8000_5010, 0, 0);
    chk("R7 removed", {31'd0, lk_hit}, 0);
    adv();
    look(32'h1234_5678, 0, 0);
    chk("R7 kept", {31'd0, lk_hit}, 1);
    adv();

    // R11 + R8: fill blocked during flush; globals survive
    flush_ng = 1;
    fill_valid = 1; fill_vpn = 20'h0AAAA; fill_ppn = 20'h1; fill_user = 1; fill_writable = 1;
    settle();
    chk("R11 ready low", {31'd0, fill_ready}, 0);
    adv();
    look(32'h0AAA_A000, 0, 0);
    chk("R11 ignored", {31'd0, lk_hit}, 0);
    adv();
    look(32'h1234_5678, 0, 0);
    chk("R8 flushed", {31'd0, lk_hit}, 0);
    adv();
    asid_we = 1; asid_wdata = 8'd3;
    settle();
    adv();
    look(32'h0077_7000, 0, 0);
    chk("R8 global kept", {31'd0, lk_hit}, 1);
    adv();

    // R9: fill order and round robin
    do_reset();
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 20'h00A00 + 20'(i), 8'd0, 0, 0, 1, 1, 0, 0);
    fill(20'h00200, 20'h00B00, 8'd0, 0, 0, 1, 1, 0, 0);
    look(32'h0010_0000, 0, 0);
    chk("R9 rr evict 0", {31'd0, lk_hit}, 0);
    adv();
    look(32'h0010_1000, 0, 0);
    chk("R9 slot1 kept", lk_pa, 32'h00A0_1000);
    adv();
    fill(20'h00201, 20'h00B01, 8'd0, 0, 0, 1, 1, 0, 0);
    look(32'h0010_1000, 0, 0);
    chk("R9 rr evict 1", {31'd0, lk_hit}, 0);
    adv();
    look(32'h0020_0000, 0, 0);
    chk("R9 new hit", lk_pa, 32'h00B0_0000);
    adv();

    // Random phase
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 40) begin
        fill_valid = 1;
        fill_vpn = {10'($urandom_range(0, 3)), 10'($urandom_range(0, 7))};
        fill_ppn = 20'($urandom);
        fill_asid = 8'($urandom_range(0, 2));
        fill_global = ($urandom_range(0, 5) == 0);
        fill_super = ($urandom_range(0, 5) == 0);
        fill_user = 1'($urandom);
        fill_writable = 1'($urandom);
        fill_dirty = 1'($urandom);
        fill_nocache = 1'($urandom);
      end
      if (r >= 40 && r < 45) begin
        inv_valid = 1;
        inv_vpn = {10'($urandom_range(0, 3)), 10'($urandom_range(0, 7))};
      end
      if (r == 45 || r == 46) flush_ng = 1;
      if ($urandom_range(0, 19) == 0) begin
        asid_we = 1;
        asid_wdata = 8'($urandom_range(0, 2));
      end
      lk_valid = ($urandom_range(0, 7) != 0);
      lk_va = {10'($urandom_range(0, 3)), 10'($urandom_range(0, 7)), 12'($urandom)};
      lk_write = 1'($urandom);
      lk_user = 1'($urandom);
      settle();
      adv();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule